// File: doc/BRIEF.md
# Frequency Sweep Sequencer

This block drives the tuning input of a phase-accumulator synthesizer through a stepped frequency sweep. Four configuration values are held steady by the surrounding logic before a sweep begins: the first tuning word, the amount added at each step, how many steps to take, and how many clock cycles each frequency lasts. One control input does three jobs. Its first rising edge sets up the sequencer, loads the first word and starts the sweep. In external mode, each later rising edge advances the sweep by one step.

In automatic mode, the sequencer steps by itself each time the dwell interval runs out. In both modes it stops on the last word and keeps it until an abort edge or a reset. An abort edge returns the block to idle and tells the waveform stage to sit at midscale. A status output can report every step or only the end of the sweep, and it stays low unless it is enabled.

Top module: `sweep_seq`

## Requirements
- R1: After reset, `tune_word` is 0, `out_mid` is 1, and `acc_clear` and `stat_pulse` are 0.
- R2: In idle, a rising edge on `ctl_in` loads `start_word` into `tune_word`, drives `out_mid` to 0 and gives a one-cycle `acc_clear` pulse. The update happens on the third rising clock edge after `ctl_in` is first sampled high: two synchronizer stages, then one edge register.
- R3: With `ext_step_mode`=0, each frequency lasts exactly `dwell_cycles` clock cycles, and then `tune_word` increases by `step_word`.
- R4: With `ext_step_mode`=1, each rising edge on `ctl_in` during a sweep adds `step_word` once. Holding `ctl_in` high for many cycles produces only one step.
- R5: After `step_total` steps, `tune_word` keeps the final value. Later `ctl_in` edges have no effect until an abort or a reset.
- R6: A rising edge on `abort_in` returns the block to idle from any state: `tune_word` becomes 0, `out_mid` becomes 1 and `acc_clear` pulses for one cycle. A later `ctl_in` edge starts a new sweep.
- R7: With `stat_eos_only`=0 and `stat_enable`=1, `stat_pulse` is high for one cycle. It rises on the clock edge one cycle after each increment of `tune_word`, the final increment included.
- R8: With `stat_eos_only`=1 and `stat_enable`=1, `stat_pulse` gives one pulse, two cycles after the final frequency change, and no pulse on intermediate steps.
- R9: With `step_total`=0, the start edge loads `start_word` and ends the sweep at once. The end-of-sweep pulse follows two cycles after the load, and later `ctl_in` edges are ignored.
- R10: With `stat_enable`=0, `stat_pulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_word | input | 24 | First tuning word of the sweep |
| step_word | input | 24 | Amount added at each step |
| step_total | input | 12 | Number of steps in the sweep |
| dwell_cycles | input | 16 | Cycles per frequency in automatic mode (0 is treated as 1) |
| ext_step_mode | input | 1 | 1: steps come from ctl_in edges; 0: steps come from the dwell timer |
| stat_eos_only | input | 1 | 1: status reports end of sweep only; 0: status reports every step |
| stat_enable | input | 1 | Lets the status output drive |
| ctl_in | input | 1 | Start and step control, asynchronous |
| abort_in | input | 1 | Abort control, asynchronous |
| tune_word | output | 24 | Current frequency tuning word |
| acc_clear | output | 1 | One-cycle pulse telling the accumulator to restart |
| out_mid | output | 1 | Tells the waveform stage to hold midscale |
| stat_pulse | output | 1 | Status pulse |

## Verification
The bench first checks the dwell boundary: the word must still hold the start value in the last dwell cycle and change in the next one. A timer that is off by one would step a cycle early or late. It then checks the status lag: the pulse must appear one cycle after a step in step mode and two cycles after the final change in end-of-sweep mode. A shared or miscounted delay line would put the pulse in the wrong cycle, or raise it on intermediate steps. Further tests hold `ctl_in` high for many cycles, send edges after the sweep has ended, and run a zero-step sweep. These catch level-triggered stepping, a sweep that runs past its end, and a count that wraps below zero. A final abort-and-restart test shows that the block leaves the finished state only through abort.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
   typedef enum logic [1:0] {
      SW_IDLE = 2'd0,
      SW_RUN  = 2'd1,
      SW_DONE = 2'd2
   } sweep_state_t;
endpackage

// File: rtl/sweep_edge.sv
// Synchronizes an asynchronous input and emits a one-cycle pulse per rising edge.
module sweep_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   initial begin
      assert (STAGES >= 2) else $error("sweep_edge: STAGES must be at least 2");
   end

   logic sync_q [STAGES];
   logic prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

   // R4: an edge gives exactly one single-cycle event
   a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/sweep_dwell.sv
// Down-counter that marks the last cycle of a dwell interval.
module sweep_dwell #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          enable,
   output logic          expire
);
   initial begin
      assert (DW >= 1) else $error("sweep_dwell: DW must be positive");
   end

   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] reload;

   assign reload = (load_val == '0) ? ONE : load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= ONE;
      else if (load)   cnt_q <= reload;
      else if (enable) cnt_q <= cnt_q - ONE;
   end

   assign expire = enable && (cnt_q == ONE);

   // R3: counting never runs below one while enabled
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/sweep_status.sv
// Delay lines that place the status pulse after a step or after the end of a sweep.
module sweep_status (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step_ev,
   input  logic eos_ev,
   input  logic eos_only,
   input  logic enable,
   output logic pulse
);
   logic step_q;
   logic eos_q1;
   logic eos_q2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= 1'b0;
         eos_q1 <= 1'b0;
         eos_q2 <= 1'b0;
         pulse  <= 1'b0;
      end else if (clear) begin
         step_q <= 1'b0;
         eos_q1 <= 1'b0;
         eos_q2 <= 1'b0;
         pulse  <= 1'b0;
      end else begin
         step_q <= step_ev;
         eos_q1 <= eos_ev;
         eos_q2 <= eos_q1;
         pulse  <= enable & (eos_only ? eos_q2 : step_q);
      end
   end

   // R10: a disabled output stays low
   a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> !pulse);
   // R7: per-step mode follows each step by one cycle
   a_r7_step_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ev && !eos_only && enable && !clear) |=> ##1 (pulse || $past(clear) || !$past(enable)));
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq #(
   parameter int FW          = 24,
   parameter int CW          = 12,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] start_word,
   input  logic [FW-1:0] step_word,
   input  logic [CW-1:0] step_total,
   input  logic [DW-1:0] dwell_cycles,
   input  logic          ext_step_mode,
   input  logic          stat_eos_only,
   input  logic          stat_enable,
   input  logic          ctl_in,
   input  logic          abort_in,
   output logic [FW-1:0] tune_word,
   output logic          acc_clear,
   output logic          out_mid,
   output logic          stat_pulse
);
   import sweep_pkg::*;

   initial begin
      assert (FW >= 2 && CW >= 1 && DW >= 1) else $error("sweep_seq: bad widths");
   end

   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   sweep_state_t  state_q;
   logic [CW-1:0] left_q;
   logic          ctl_rise;
   logic          abort_rise;
   logic          dwell_end;
   logic          start_ev;
   logic          step_ev;
   logic          last_step;
   logic          eos_ev;

   sweep_edge #(.STAGES(SYNC_STAGES)) u_ctl_edge (
      .clk(clk), .rst_n(rst_n), .din(ctl_in), .rise(ctl_rise));

   sweep_edge #(.STAGES(SYNC_STAGES)) u_abort_edge (
      .clk(clk), .rst_n(rst_n), .din(abort_in), .rise(abort_rise));

   assign start_ev  = !abort_rise && (state_q == SW_IDLE) && ctl_rise;
   assign step_ev   = !abort_rise && (state_q == SW_RUN) &&
                      (ext_step_mode ? ctl_rise : dwell_end);
   assign last_step = (left_q == CNT_ONE);
   assign eos_ev    = (start_ev && (step_total == '0)) || (step_ev && last_step);

   sweep_dwell #(.DW(DW)) u_dwell (
      .clk(clk), .rst_n(rst_n),
      .load(start_ev || step_ev),
      .load_val(dwell_cycles),
      .enable((state_q == SW_RUN) && !ext_step_mode),
      .expire(dwell_end));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SW_IDLE;
         left_q    <= '0;
         tune_word <= '0;
         acc_clear <= 1'b0;
         out_mid   <= 1'b1;
      end else begin
         acc_clear <= 1'b0;
         if (abort_rise) begin
            state_q   <= SW_IDLE;
            left_q    <= '0;
            tune_word <= '0;
            acc_clear <= 1'b1;
            out_mid   <= 1'b1;
         end else if (start_ev) begin
            tune_word <= start_word;
            left_q    <= step_total;
            acc_clear <= 1'b1;
            out_mid   <= 1'b0;
            state_q   <= (step_total == '0) ? SW_DONE : SW_RUN;
         end else if (step_ev) begin
            tune_word <= tune_word + step_word;
            left_q    <= left_q - CNT_ONE;
            if (last_step) state_q <= SW_DONE;
         end
      end
   end

   sweep_status u_status (
      .clk(clk), .rst_n(rst_n),
      .clear(abort_rise),
      .step_ev(step_ev),
      .eos_ev(eos_ev),
      .eos_only(stat_eos_only),
      .enable(stat_enable),
      .pulse(stat_pulse));

   // R5: a finished sweep holds its word until abort
   a_r5_hold_final: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SW_DONE && !abort_rise) |=> $stable(tune_word));
   // R6: abort forces idle output state
   a_r6_abort_mid: assert property (@(posedge clk) disable iff (!rst_n)
      abort_rise |=> (out_mid && tune_word == '0 && acc_clear));
   // R3 / R4: each step adds exactly one increment
   a_r4_step_add: assert property (@(posedge clk) disable iff (!rst_n)
      step_ev |=> (tune_word == $past(tune_word) + $past(step_word)));
   // R2: a start leaves midscale and pulses the clear
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (!out_mid && acc_clear));
endmodule

// File: tb/tb_sweep_seq.sv
module tb_sweep_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] start_word = '0;
   logic [23:0] step_word = '0;
   logic [11:0] step_total = '0;
   logic [15:0] dwell_cycles = '0;
   logic        ext_step_mode = 1'b1;
   logic        stat_eos_only = 1'b0;
   logic        stat_enable = 1'b0;
   logic        ctl_in = 1'b0;
   logic        abort_in = 1'b0;
   logic [23:0] tune_word;
   logic        acc_clear;
   logic        out_mid;
   logic        stat_pulse;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sweep_seq dut (
      .clk(clk), .rst_n(rst_n),
      .start_word(start_word), .step_word(step_word),
      .step_total(step_total), .dwell_cycles(dwell_cycles),
      .ext_step_mode(ext_step_mode), .stat_eos_only(stat_eos_only),
      .stat_enable(stat_enable), .ctl_in(ctl_in), .abort_in(abort_in),
      .tune_word(tune_word), .acc_clear(acc_clear),
      .out_mid(out_mid), .stat_pulse(stat_pulse));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act == exp, req, act, exp);
   endtask

   // the design reacts on the third clock edge after the set; return just after it
   task automatic pulse_ctl(input int w);
      ctl_in = 1'b1;
      repeat (w) tick();
      ctl_in = 1'b0;
      if (w < 3) repeat (3 - w) tick();
   endtask

   task automatic pulse_abort();
      abort_in = 1'b1;
      repeat (2) tick();
      abort_in = 1'b0;
      tick();
   endtask

   task automatic t_reset();
      chk_eq("R1 tune_word", tune_word, 0);
      chk_eq("R1 out_mid", out_mid, 1);
      chk_eq("R1 acc_clear", acc_clear, 0);
      chk_eq("R1 stat_pulse", stat_pulse, 0);
   endtask

   task automatic t_external();
      ext_step_mode = 1; stat_eos_only = 0; stat_enable = 1;
      start_word = 24'h100000; step_word = 24'h000123; step_total = 3;
      pulse_ctl(2);
      chk_eq("R2 start word", tune_word, 24'h100000);
      chk_eq("R2 acc_clear", acc_clear, 1);
      chk_eq("R2 out_mid", out_mid, 0);
      tick();
      chk_eq("R2 acc_clear one cycle", acc_clear, 0);
      pulse_ctl(2);
      chk_eq("R4 step1", tune_word, 24'h100123);
      chk_eq("R7 no pulse yet", stat_pulse, 0);
      tick();
      chk_eq("R7 pulse", stat_pulse, 1);
      tick();
      chk_eq("R7 pulse width", stat_pulse, 0);
      pulse_ctl(2);
      chk_eq("R4 step2", tune_word, 24'h100246);
      pulse_ctl(2);
      chk_eq("R4 step3", tune_word, 24'h100369);
      tick();
      chk_eq("R7 final step pulse", stat_pulse, 1);
      pulse_ctl(2);
      chk_eq("R5 edge after end ignored", tune_word, 24'h100369);
      repeat (5) tick();
      chk_eq("R5 hold", tune_word, 24'h100369);
   endtask

   task automatic t_abort_restart();
      pulse_abort();
      chk_eq("R6 word zero", tune_word, 0);
      chk_eq("R6 out_mid", out_mid, 1);
      chk_eq("R6 acc_clear", acc_clear, 1);
      tick();
      pulse_ctl(2);
      chk_eq("R6 restart", tune_word, 24'h100000);
   endtask

   task automatic t_held_level();
      pulse_ctl(10);
      chk_eq("R4 held level one step", tune_word, 24'h100123);
      repeat (3) tick();
      chk_eq("R4 held level still one step", tune_word, 24'h100123);
      pulse_abort();
   endtask

   task automatic t_auto();
      ext_step_mode = 0; stat_eos_only = 0; stat_enable = 1;
      start_word = 24'h040000; step_word = 24'h001000; step_total = 2;
      dwell_cycles = 4;
      pulse_ctl(2);
      chk_eq("R3 start", tune_word, 24'h040000);
      repeat (3) tick();
      chk_eq("R3 last dwell cycle", tune_word, 24'h040000);
      tick();
      chk_eq("R3 first step", tune_word, 24'h041000);
      chk_eq("R7 auto no pulse yet", stat_pulse, 0);
      tick();
      chk_eq("R7 auto pulse", stat_pulse, 1);
      tick();
      chk_eq("R7 auto pulse end", stat_pulse, 0);
      tick();
      chk_eq("R3 second dwell", tune_word, 24'h041000);
      tick();
      chk_eq("R3 second step", tune_word, 24'h042000);
      repeat (50) tick();
      chk_eq("R5 auto hold", tune_word, 24'h042000);
      pulse_abort();
   endtask

   task automatic t_eos_only();
      ext_step_mode = 1; stat_eos_only = 1; stat_enable = 1;
      start_word = 24'h200000; step_word = 24'h000010; step_total = 2;
      pulse_ctl(2);
      pulse_ctl(2);
      chk_eq("R8 intermediate step", tune_word, 24'h200010);
      for (int i = 0; i < 3; i++) begin
         chk_eq("R8 no pulse on intermediate", stat_pulse, 0);
         tick();
      end
      pulse_ctl(2);
      chk_eq("R8 final word", tune_word, 24'h200020);
      chk_eq("R8 lag0", stat_pulse, 0);
      tick();
      chk_eq("R8 lag1", stat_pulse, 0);
      tick();
      chk_eq("R8 end pulse", stat_pulse, 1);
      tick();
      chk_eq("R8 end pulse width", stat_pulse, 0);
      pulse_abort();
   endtask

   task automatic t_disabled();
      ext_step_mode = 1; stat_eos_only = 0; stat_enable = 0;
      step_total = 2;
      pulse_ctl(2);
      pulse_ctl(2);
      for (int i = 0; i < 3; i++) begin
         chk_eq("R10 disabled", stat_pulse, 0);
         tick();
      end
      pulse_abort();
   endtask

   task automatic t_zero_count();
      ext_step_mode = 1; stat_eos_only = 1; stat_enable = 1;
      start_word = 24'h0ABCDE; step_total = 0;
      pulse_ctl(2);
      chk_eq("R9 start loaded", tune_word, 24'h0ABCDE);
      tick();
      chk_eq("R9 lag", stat_pulse, 0);
      tick();
      chk_eq("R9 end pulse", stat_pulse, 1);
      pulse_ctl(2);
      chk_eq("R9 edge ignored", tune_word, 24'h0ABCDE);
      pulse_abort();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_external();
      t_abort_restart();
      t_held_level();
      t_auto();
      t_eos_only();
      t_disabled();
      t_zero_count();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %h expected %h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule